// File: doc/BRIEF.md
# Serial Controller Interrupt Status Register

This block holds the interrupt state of a serial bus controller in one 32-bit register word. Six event sources feed it. Three of them are latched and stay set until software clears them: transfer complete, NACK seen and arbitration lost. The other three are live levels that drop when the FIFO logic is serviced: TX room, RX data waiting and FIFO fault. Because the FIFO logic owns those three conditions, the status bits follow them and need no clear action.

Each source has two gates, a mask bit and an enable bit. A source drives the single level interrupt output only when its status is set, its enable is 1 and its mask is 0. One write port loads the mask and enable fields as a whole. The same write can carry one-shot clear strobes for the latched sources. The full word is always visible on the read port.

Top module: `irq_status_reg`

## Requirements
- R1: While reset is asserted and just after it is released, the three latched bits are 0, the mask field is all ones, the enable field is all zeros and the interrupt output is 0.
- R2: Status bits 0 to 5 read, in that order: transfer complete, TX room, RX data waiting, NACK, arbitration lost, FIFO fault.
- R3: A one-cycle pulse on `xfer_done_i`, `nack_i` or `arb_lost_i` sets status bit 0, 3 or 4. The bit then stays set with no further pulse.
- R4: A write with bit 16, 19 or 20 set clears status bit 0, 3 or 4 respectively. A 0 in any of these bits leaves its status bit unchanged.
- R5: If a latched event pulse and its clear strobe occur in the same cycle, the status bit is set after that edge.
- R6: Status bits 1, 2 and 5 show the current levels of `tx_room_i`, `rx_avail_i` and `fifo_fault_i` in the same cycle. They clear when those inputs fall.
- R7: Bits 13:8 of a write load the mask field, with source n at bit 8+n. The field reads back at the same positions.
- R8: Bits 29:24 of a write load the enable field, with source n at bit 24+n. The field reads back at the same positions.
- R9: `irq_o` is 1 exactly when some source n has status 1, enable 1 and mask 0.
- R10: Bits 7:6, 15:14, 23:16 and 31:30 always read 0, and that includes the clear bits after they are written as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Write data: mask, clear strobes and enable |
| rd_data_o | output | 32 | Current register word |
| xfer_done_i | input | 1 | Transfer complete pulse |
| nack_i | input | 1 | NACK received pulse |
| arb_lost_i | input | 1 | Arbitration lost pulse |
| tx_room_i | input | 1 | TX FIFO has free space (level) |
| rx_avail_i | input | 1 | RX FIFO holds data (level) |
| fifo_fault_i | input | 1 | A FIFO overflow or underflow flag is set (level) |
| irq_o | output | 1 | Level interrupt output |

## Verification
The bench drives a clear strobe in the same cycle as its own event. A design that lets the clear win would lose that event, and the read-back would show bit 0 at 0. It also writes an all-zero word and checks that the latched bits survive. A design that treats a 0 in a clear bit as an action would drop pending events at that point. Other checks show a masked source with its enable set giving no interrupt, and an enabled source whose level has fallen giving no interrupt either. A final all-ones write shows that the clear and reserved bits read back as 0 while every source remains masked.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int NSRC     = 6;
  localparam int ST_LSB   = 0;
  localparam int MASK_LSB = 8;
  localparam int CLR_LSB  = 16;
  localparam int EN_LSB   = 24;

  localparam int SRC_DONE  = 0;
  localparam int SRC_TXRM  = 1;
  localparam int SRC_RXAV  = 2;
  localparam int SRC_NACK  = 3;
  localparam int SRC_ARB   = 4;
  localparam int SRC_FAULT = 5;

  localparam int NSTICKY = 3;
endpackage

// File: rtl/irq_sticky_bit.sv
module irq_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;
  logic q_d;

  always_comb begin
    q_d = q_q;
    if (clr_i) q_d = 1'b0;
    if (set_i) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

  p_event_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  p_event_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && clr_i) |=> q_o);
  p_clear_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/irq_cfg_field.sv
module irq_cfg_field #(
  parameter int          W       = 6,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] fld_q;
  logic [W-1:0] fld_d;

  always_comb begin
    fld_d = fld_q;
    if (ld_i) fld_d = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fld_q <= RST_VAL;
    else        fld_q <= fld_d;
  end

  assign q_o = fld_q;

  p_field_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> (q_o == $past(d_i)));
  p_field_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_i |=> $stable(q_o));
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int N = 6
) (
  input  logic [N-1:0] status_i,
  input  logic [N-1:0] enable_i,
  input  logic [N-1:0] mask_i,
  output logic         irq_o
);
  logic [N-1:0] live;

  always_comb begin
    for (int n = 0; n < N; n++) begin
      live[n] = status_i[n] & enable_i[n] & ~mask_i[n];
    end
  end

  assign irq_o = |live;
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_status_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              xfer_done_i,
  input  logic              nack_i,
  input  logic              arb_lost_i,
  input  logic              tx_room_i,
  input  logic              rx_avail_i,
  input  logic              fifo_fault_i,
  output logic              irq_o
);
  localparam int STICKY_POS [NSTICKY] = '{SRC_DONE, SRC_NACK, SRC_ARB};

  logic [NSTICKY-1:0] sticky_evt;
  logic [NSTICKY-1:0] sticky_q;
  logic [NSRC-1:0]    status;
  logic [NSRC-1:0]    mask_q;
  logic [NSRC-1:0]    en_q;

  assign sticky_evt = {arb_lost_i, nack_i, xfer_done_i};

  for (genvar k = 0; k < NSTICKY; k++) begin : g_sticky
    logic clr_k;
    assign clr_k = wr_en_i & wr_data_i[CLR_LSB + STICKY_POS[k]];
    irq_sticky_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (sticky_evt[k]),
      .clr_i (clr_k),
      .q_o   (sticky_q[k])
    );
  end

  always_comb begin
    status            = '0;
    status[SRC_DONE]  = sticky_q[0];
    status[SRC_TXRM]  = tx_room_i;
    status[SRC_RXAV]  = rx_avail_i;
    status[SRC_NACK]  = sticky_q[1];
    status[SRC_ARB]   = sticky_q[2];
    status[SRC_FAULT] = fifo_fault_i;
  end

  irq_cfg_field #(.W(NSRC), .RST_VAL({NSRC{1'b1}})) u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_i  (wr_en_i),
    .d_i   (wr_data_i[MASK_LSB +: NSRC]),
    .q_o   (mask_q)
  );

  irq_cfg_field #(.W(NSRC), .RST_VAL({NSRC{1'b0}})) u_enable (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_i  (wr_en_i),
    .d_i   (wr_data_i[EN_LSB +: NSRC]),
    .q_o   (en_q)
  );

  irq_combine #(.N(NSRC)) u_combine (
    .status_i (status),
    .enable_i (en_q),
    .mask_i   (mask_q),
    .irq_o    (irq_o)
  );

  always_comb begin
    rd_data_o                     = '0;
    rd_data_o[ST_LSB   +: NSRC]   = status;
    rd_data_o[MASK_LSB +: NSRC]   = mask_q;
    rd_data_o[EN_LSB   +: NSRC]   = en_q;
  end

  p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o[MASK_LSB +: NSRC] == {NSRC{1'b1}}) |-> !irq_o);
  p_level_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[SRC_RXAV] == rx_avail_i);
endmodule

// File: tb/irq_status_reg_tb_top.sv
module irq_status_reg_tb_top;
  localparam int VW = 72;
  localparam int NV = 13;

  // {wr, wdata[31:0], ev{arb,nack,done}, lv{fault,rx,tx}, exp_rd[31:0], exp_irq}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 32'h0000_0000, 3'b001, 3'b000, 32'h0000_3F01, 1'b0}, // R3 done sets
    {1'b0, 32'h0000_0000, 3'b110, 3'b001, 32'h0000_3F1B, 1'b0}, // R2 nack/arb + tx level
    {1'b1, 32'h3F00_0000, 3'b000, 3'b001, 32'h3F00_001B, 1'b1}, // R8 enable all, unmask
    {1'b1, 32'h3F01_0000, 3'b000, 3'b000, 32'h3F00_0018, 1'b1}, // R4 clear done only
    {1'b1, 32'h3F18_0000, 3'b000, 3'b000, 32'h3F00_0000, 1'b0}, // R4 clear nack+arb
    {1'b0, 32'h0000_0000, 3'b000, 3'b010, 32'h3F00_0004, 1'b1}, // R6 rx level
    {1'b1, 32'h3F00_0400, 3'b000, 3'b010, 32'h3F00_0404, 1'b0}, // R7 mask rx
    {1'b1, 32'h2000_0400, 3'b000, 3'b100, 32'h2000_0420, 1'b1}, // R9 fault enabled
    {1'b1, 32'h2000_0400, 3'b000, 3'b011, 32'h2000_0406, 1'b0}, // R9 only disabled live
    {1'b1, 32'h2001_0400, 3'b001, 3'b000, 32'h2000_0401, 1'b0}, // R5 event wins
    {1'b1, 32'h0000_0000, 3'b000, 3'b000, 32'h0000_0001, 1'b0}, // R4 zero no effect
    {1'b1, 32'h01FF_0000, 3'b000, 3'b000, 32'h0100_0000, 1'b0}, // R10 clear bits read 0
    {1'b0, 32'h0000_0000, 3'b001, 3'b000, 32'h0100_0001, 1'b1}  // R9 done enabled
  };

  function automatic string vec_tag(input int i);
    case (i)
      0:  return "R3";
      1:  return "R2";
      2:  return "R8";
      3:  return "R4";
      4:  return "R4";
      5:  return "R6";
      6:  return "R7";
      7:  return "R9";
      8:  return "R9";
      9:  return "R5";
      10: return "R4";
      11: return "R10";
      default: return "R9";
    endcase
  endfunction

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        ev_done, ev_nack, ev_arb;
  logic        lv_tx, lv_rx, lv_fault;
  logic        irq;

  int n_chk;
  int n_bad;
  bit done_flag;

  irq_status_reg dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en_i      (wr_en),
    .wr_data_i    (wr_data),
    .rd_data_o    (rd_data),
    .xfer_done_i  (ev_done),
    .nack_i       (ev_nack),
    .arb_lost_i   (ev_arb),
    .tx_room_i    (lv_tx),
    .rx_avail_i   (lv_rx),
    .fifo_fault_i (lv_fault),
    .irq_o        (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] exp_rd, input logic exp_irq);
    n_chk++;
    if (rd_data !== exp_rd || irq !== exp_irq) begin
      n_bad++;
      $display("FAIL %s: rd=%h irq=%b expected rd=%h irq=%b", tag, rd_data, irq, exp_rd, exp_irq);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done_flag = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    ev_done = 0; ev_nack = 0; ev_arb = 0;
    lv_tx = 0; lv_rx = 0; lv_fault = 0;
    repeat (2) @(posedge clk);
    #2 check("R1", 32'h0000_3F00, 1'b0);   // in reset
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #2 check("R1", 32'h0000_3F00, 1'b0);   // after release

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      @(negedge clk);
      wr_en   = v[71];
      wr_data = v[70:39];
      {ev_arb, ev_nack, ev_done} = v[38:36];
      {lv_fault, lv_rx, lv_tx}   = v[35:33];
      @(posedge clk);
      #2 check(vec_tag(i), v[32:1], v[0]);
    end

    // R10: all-ones write, reserved and clear bits read 0, all masked
    @(negedge clk);
    wr_en = 1'b1; wr_data = 32'hFFFF_FFFF;
    {ev_arb, ev_nack, ev_done} = 3'b000;
    {lv_fault, lv_rx, lv_tx}   = 3'b000;
    @(posedge clk);
    #2 check("R10", 32'h3F00_3F00, 1'b0);

    // R3: latched nack holds over idle cycles; masked so irq stays low
    @(negedge clk);
    wr_en = 1'b0; ev_nack = 1'b1;
    @(negedge clk);
    ev_nack = 1'b0;
    repeat (3) @(posedge clk);
    #2 check("R3", 32'h3F00_3F08, 1'b0);

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R1", 32'h0000_3F00, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2 check("R1", 32'h0000_3F00, 1'b0);

    finish_run();
  end

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    finish_run();
  end
endmodule